// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target Engine

This block is the bus-facing controller of a serial EEPROM target on a two-wire (I2C-style) bus. It oversamples the raw clock and data lines and finds START and STOP conditions. It checks the device-address header against its own identity and decodes the direction bit. It then takes a word address or write data from the host, or returns stored bytes MSB first. The data line is open-drain: the block only ever asks the pad to pull low.

The array itself and its programming controller sit outside. The engine reaches the array through a synchronous port: a one-cycle read request returns data on the next cycle, and a one-cycle write strobe carries address and data. A persistent address counter follows the last accessed location and wraps at the top of the array. This gives current-address reads, random reads (a dummy write of the word address followed by a repeated START) and sequential reads. While the controller reports an internal programming cycle, the engine withholds its acknowledge, so a host can poll for completion.

Top module: `twi_eeprom_target`

## Requirements
- R1: A START seen in any state begins a new header reception, and this includes a repeated START in the middle of a transfer. A STOP returns the engine to idle with SDA released.
- R2: The header byte carries the device type in bits 7:4 (parameter `DEV_ID`, default 4'hA). Bits 3:1 hold the chip-select and page bits, with the page bits (log2(MEM_BYTES)-8 of them) in the lowest positions. Bit 0 is the direction: 1 means read, 0 means write. A matching header is acknowledged by pulling SDA low during the ninth clock.
- R3: A header whose device type or select bits do not match gets no acknowledge. The rest of that transfer is ignored until the next START, and the address counter is left unchanged.
- R4: While `busy_i` is high, the engine gives no acknowledge even to a matching header.
- R5: In a write, the engine acknowledges the word address and loads the counter with {page bits, word address}. It acknowledges each following data byte, issues it as a one-cycle write strobe at the counter, and then increments the counter.
- R6: A current-address read returns the byte at the counter, MSB first, and then increments the counter. The result is the last accessed address plus one, whether that last access was a read or a write.
- R7: A random read (write header, word address, repeated START, read header) returns the byte at the written word address.
- R8: A master ACK after a data byte makes the engine send the next byte. The counter wraps from the top of the array to address 0.
- R9: A master NACK ends the read. SDA stays released and no further read request is issued until the next START.
- R10: The engine changes its SDA drive only while the synchronized SCL is low.
- R11: A read request lasts exactly one cycle and is followed by a counter increment of one. A read request and a write strobe never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1; release when 0 |
| chip_sel_i | input | 3 | Strap value compared with header select bits not used for paging |
| busy_i | input | 1 | Internal programming cycle in progress |
| mem_addr_o | output | log2(MEM_BYTES) | Array address (the counter) |
| mem_rd_o | output | 1 | One-cycle read request |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |

## Verification
The hardest case to reach is the wrap of a sequential read across the top of the array, together with the counter value that a later current-address read must see. The stimulus reaches it with a random read to the last location, using a page bit in the header and word address 8'hFF. The master then ACKs once and NACKs the second byte, and a following current-address read must return the byte at address 1. A rejected header sent after that must leave the counter unchanged, and the next current-address read checks this.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WPUT,
    ST_WDAT_ACK,
    ST_RREQ,
    ST_RLOAD,
    ST_RDAT,
    ST_RACK
  } twi_state_e;
endpackage

// File: rtl/twi_bus_sync.sv
`timescale 1ns/1ps
module twi_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_m, scl_s, scl_d;
  logic sda_m, sda_s, sda_d;

  // two-flop synchronizers plus one history stage; bus idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      scl_s <= 1'b1;
      scl_d <= 1'b1;
      sda_m <= 1'b1;
      sda_s <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i;
      scl_s <= scl_m;
      scl_d <= scl_s;
      sda_m <= sda_i;
      sda_s <= sda_m;
      sda_d <= sda_s;
    end
  end

  assign scl_o      = scl_s;
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_dev_match.sv
`timescale 1ns/1ps
module twi_dev_match #(
  parameter logic [3:0] DEV_ID    = 4'hA,
  parameter int         PAGE_BITS = 1,
  parameter int         AW        = 9
) (
  input  logic [7:0]    hdr_i,
  input  logic [2:0]    sel_i,
  output logic          hit_o,
  output logic [AW-1:0] page_o
);
  generate
    if (PAGE_BITS == 0) begin : g_nopage
      assign hit_o  = (hdr_i[7:4] == DEV_ID) && (hdr_i[3:1] == sel_i);
      assign page_o = '0;
    end else if (PAGE_BITS >= 3) begin : g_allpage
      logic unused_sel;
      assign unused_sel = ^sel_i;
      assign hit_o  = (hdr_i[7:4] == DEV_ID);
      assign page_o = {hdr_i[3:1], 8'h00};
    end else begin : g_mixed
      logic unused_sel_lo;
      assign unused_sel_lo = ^sel_i[PAGE_BITS-1:0];
      assign hit_o  = (hdr_i[7:4] == DEV_ID) &&
                      (hdr_i[3:PAGE_BITS+1] == sel_i[2:PAGE_BITS]);
      assign page_o = {hdr_i[PAGE_BITS:1], 8'h00};
    end
  endgenerate
endmodule

// File: rtl/twi_addr_ctr.sv
`timescale 1ns/1ps
module twi_addr_ctr #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] cnt_o
);
  logic [AW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i | inc_i;

  // power-of-two depth: natural overflow wraps to zero
  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/twi_eeprom_target.sv
`timescale 1ns/1ps
module twi_eeprom_target
  import twi_pkg::*;
#(
  parameter int         MEM_BYTES = 512,
  parameter logic [3:0] DEV_ID    = 4'hA
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_oe_o,
  input  logic [2:0]                   chip_sel_i,
  input  logic                         busy_i,
  output logic [$clog2(MEM_BYTES)-1:0] mem_addr_o,
  output logic                         mem_rd_o,
  input  logic [7:0]                   mem_rdata_i,
  output logic                         mem_we_o,
  output logic [7:0]                   mem_wdata_o
);
  localparam int AW        = $clog2(MEM_BYTES);
  localparam int PAGE_BITS = AW - 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  twi_bus_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  twi_state_e    state_q, state_d;
  logic [3:0]    bcnt_q, bcnt_d;
  logic [7:0]    shreg_q, shreg_d;
  logic          oe_q, oe_d;
  logic          rw_q, rw_d;
  logic          mack_q, mack_d;
  logic [AW-1:0] page_q, page_d;
  logic          hit;
  logic [AW-1:0] page_hdr;
  logic          ctr_load, ctr_inc;
  logic [AW-1:0] ctr;

  twi_dev_match #(
    .DEV_ID    (DEV_ID),
    .PAGE_BITS (PAGE_BITS),
    .AW        (AW)
  ) u_match (
    .hdr_i  (shreg_q),
    .sel_i  (chip_sel_i),
    .hit_o  (hit),
    .page_o (page_hdr)
  );

  twi_addr_ctr #(.AW(AW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_ni),
    .load_i     (ctr_load),
    .load_val_i (page_q | AW'(shreg_q)),
    .inc_i      (ctr_inc),
    .cnt_o      (ctr)
  );

  always_comb begin
    state_d  = state_q;
    bcnt_d   = bcnt_q;
    shreg_d  = shreg_q;
    oe_d     = oe_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    page_d   = page_q;
    ctr_load = 1'b0;
    ctr_inc  = 1'b0;
    if (start) begin
      state_d = ST_DEV;
      bcnt_d  = 4'd0;
      oe_d    = 1'b0;
    end else if (stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: ;
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise && bcnt_q != 4'd8) begin
            shreg_d = {shreg_q[6:0], sda_s};
            bcnt_d  = bcnt_q + 4'd1;
          end else if (scl_fall && bcnt_q == 4'd8) begin
            if (state_q == ST_DEV) begin
              if (hit && !busy_i) begin
                state_d = ST_DEV_ACK;
                oe_d    = 1'b1;
                rw_d    = shreg_q[0];
                page_d  = page_hdr;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_WADR) begin
              state_d  = ST_WADR_ACK;
              oe_d     = 1'b1;
              ctr_load = 1'b1;
            end else begin
              state_d = ST_WPUT;
              oe_d    = 1'b1;
            end
          end
        end
        ST_WPUT: begin
          ctr_inc = 1'b1;
          state_d = ST_WDAT_ACK;
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            bcnt_d  = 4'd0;
            state_d = rw_q ? ST_RREQ : ST_WADR;
          end
        end
        ST_WADR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            bcnt_d  = 4'd0;
            state_d = ST_WDAT;
          end
        end
        ST_RREQ: begin
          ctr_inc = 1'b1;
          state_d = ST_RLOAD;
        end
        ST_RLOAD: begin
          shreg_d = mem_rdata_i;
          oe_d    = ~mem_rdata_i[7];
          bcnt_d  = 4'd0;
          state_d = ST_RDAT;
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bcnt_d = bcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bcnt_q == 4'd8) begin
              oe_d    = 1'b0;
              state_d = ST_RACK;
            end else begin
              oe_d    = ~shreg_q[6];
              shreg_d = {shreg_q[6:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise)      mack_d  = ~sda_s;
          else if (scl_fall) state_d = mack_q ? ST_RREQ : ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bcnt_q  <= 4'd0;
      shreg_q <= 8'h00;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      shreg_q <= shreg_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      page_q  <= page_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_addr_o  = ctr;
  assign mem_rd_o    = (state_q == ST_RREQ);
  assign mem_we_o    = (state_q == ST_WPUT);
  assign mem_wdata_o = shreg_q;
endmodule

// File: rtl/twi_eeprom_target_chk.sv
`timescale 1ns/1ps
module twi_eeprom_target_chk
  import twi_pkg::*;
#(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          start,
  input logic          stop,
  input logic          sda_oe_o,
  input logic          busy_i,
  input twi_state_e    state_q,
  input logic          mem_rd_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o
);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((sda_oe_o != $past(sda_oe_o)) && !$past(start) && !$past(stop)) |-> !$past(scl_s));

  // R4
  busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(state_q == ST_DEV_ACK) |-> !$past(busy_i));

  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  // R11
  rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(mem_rd_o && mem_we_o));

  // R11
  rd_inc_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_o |=> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  // R5
  we_inc_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we_o |=> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));
endmodule

bind twi_eeprom_target twi_eeprom_target_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .start      (start),
  .stop       (stop),
  .sda_oe_o   (sda_oe_o),
  .busy_i     (busy_i),
  .state_q    (state_q),
  .mem_rd_o   (mem_rd_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/twi_eeprom_target_tb.sv
`timescale 1ns/1ps
module twi_eeprom_target_tb;
  localparam int MEM_BYTES = 512;
  localparam int AW        = 9;
  localparam int Q         = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, scl_m, sda_m, busy, sda_oe, mem_rd, mem_we;
  logic [2:0]    chip_sel;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata, mem_wdata;
  logic          sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  twi_eeprom_target #(.MEM_BYTES(MEM_BYTES), .DEV_ID(4'hA)) u_dut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_bus),
    .sda_oe_o (sda_oe), .chip_sel_i (chip_sel), .busy_i (busy),
    .mem_addr_o (mem_addr), .mem_rd_o (mem_rd), .mem_rdata_i (mem_rdata),
    .mem_we_o (mem_we), .mem_wdata_o (mem_wdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 11);
  endfunction

  // external array model
  logic [7:0] mem [MEM_BYTES];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= pat(i);
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // protocol monitors (R10, R11)
  int   oe_viol = 0, rd_viol = 0;
  logic prev_oe = 1'b0, prev_scl = 1'b1, prev_rd = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != prev_oe && scl_m && prev_scl) oe_viol++;
      if (prev_rd && (mem_rd || mem_addr != AW'(prev_addr + 1'b1))) rd_viol++;
      if (mem_rd && mem_we) rd_viol++;
    end
    prev_oe   = sda_oe;
    prev_scl  = scl_m;
    prev_rd   = mem_rd;
    prev_addr = mem_addr;
  end

  // scoreboard
  logic [7:0] got_q[$], exp_q[$];
  string      tag_q[$];
  logic [7:0] sb_g, sb_e;
  string      sb_t;
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0) begin
      sb_g = got_q.pop_front();
      sb_e = exp_q.pop_front();
      sb_t = tag_q.pop_front();
      chk(sb_g == sb_e, sb_t, sb_g, sb_e);
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  // driver: read one byte and push expectation into the scoreboard
  task automatic rd_expect(input logic [7:0] exp, input logic mack, input string tag);
    logic [7:0] b;
    b = 8'h00;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_bus}; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    got_q.push_back(b);
  endtask

  function automatic logic [7:0] hdr(input logic rw, input logic pg);
    return {4'hA, 2'b01, pg, rw};
  endfunction

  logic a;

  initial begin
    tick(150000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0; chip_sel = 3'b010;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    // R1: idle after reset, SDA released, no strobes
    chk(sda_oe == 1'b0 && mem_rd == 1'b0 && mem_we == 1'b0, "R1 reset idle",
        {sda_oe, mem_rd, mem_we}, 0);

    // write 0x010 <- A5, 0x011 <- 3C
    bus_start();
    send(hdr(1'b0, 1'b0), a); chk(a, "R2 write header ack", a, 1);
    send(8'h10, a);           chk(a, "R5 word address ack", a, 1);
    send(8'hA5, a);           chk(a, "R5 data ack", a, 1);
    send(8'h3C, a);           chk(a, "R5 data ack", a, 1);
    bus_stop();
    chk(sda_oe == 1'b0, "R1 stop releases SDA", sda_oe, 0);

    // busy polling
    busy = 1'b1;
    bus_start();
    send(hdr(1'b0, 1'b0), a); chk(!a, "R4 no ack while busy", a, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send(hdr(1'b0, 1'b0), a); chk(a, "R4 ack after busy", a, 1);
    bus_stop();

    // current-address read after write: 0x012
    bus_start();
    send(hdr(1'b1, 1'b0), a); chk(a, "R2 read header ack", a, 1);
    rd_expect(pat(12'h012), 1'b0, "R6 current read after write");
    bus_stop();

    // random read at top of array, sequential wrap
    bus_start();
    send(hdr(1'b0, 1'b1), a); chk(a, "R7 dummy write ack", a, 1);
    send(8'hFF, a);           chk(a, "R7 word ack", a, 1);
    bus_start();
    send(hdr(1'b1, 1'b0), a); chk(a, "R1 repeated start header ack", a, 1);
    rd_expect(pat(12'h1FF), 1'b1, "R7 random read top");
    rd_expect(pat(0), 1'b0, "R8 wrap to zero");
    tick(4 * Q);
    chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
    bus_stop();

    // current read continues after last read
    bus_start();
    send(hdr(1'b1, 1'b0), a); chk(a, "R6 read header ack", a, 1);
    rd_expect(pat(1), 1'b0, "R9 counter after nack");
    bus_stop();

    // mismatched headers ignored
    bus_start();
    send({4'hA, 2'b11, 1'b0, 1'b0}, a); chk(!a, "R3 wrong select nack", a, 0);
    send(8'h00, a);                    chk(!a, "R3 rest ignored", a, 0);
    bus_stop();
    bus_start();
    send({4'h5, 2'b01, 1'b0, 1'b1}, a); chk(!a, "R3 wrong type nack", a, 0);
    bus_stop();
    bus_start();
    send(hdr(1'b1, 1'b0), a); chk(a, "R3 header ack", a, 1);
    rd_expect(pat(2), 1'b0, "R3 counter unchanged");
    bus_stop();

    // random + sequential over written bytes
    bus_start();
    send(hdr(1'b0, 1'b0), a); chk(a, "R7 dummy write ack", a, 1);
    send(8'h10, a);           chk(a, "R7 word ack", a, 1);
    bus_start();
    send(hdr(1'b1, 1'b0), a); chk(a, "R7 read header ack", a, 1);
    rd_expect(8'hA5, 1'b1, "R5 written byte 0x010");
    rd_expect(8'h3C, 1'b1, "R8 sequential 0x011");
    rd_expect(pat(12'h012), 1'b0, "R8 sequential 0x012");
    bus_stop();

    tick(20);
    chk(oe_viol == 0, "R10 SDA drive change with SCL high", oe_viol, 0);
    chk(rd_viol == 0, "R11 read request pulse and increment", rd_viol, 0);
    summary();
    $finish;
  end
endmodule